// File: doc/BRIEF.md
# Address-Strobed Page and Configuration Controller

This block sits on one chip-select window of a processor's external memory bus and accepts writes only. The address of a write, not its data, carries the command: bits above a chosen position pick one of four regions, and address bit 0 picks the value. Two regions hold page bits, one for the top address line of a paged flash and one for the top address line of a paged SRAM. A third region sets the level of an active-high FPGA program (return-to-unconfigured) output.

The fourth region produces a single configuration clock pulse for each write, with the data bit captured from data bit 0 of that same write. This lets software shift an FPGA bitstream one bit per bus access. Writes with the chip select or write strobe low, and writes that land on an unmapped address, change nothing.

Top module: `addr_strobe_ctl`

## Requirements
- R1: After reset the flash page, SRAM page, program output, configuration clock and configuration data outputs are all 0.
- R2: A write whose region field `addr[ADDR_W-1:SEL_LSB]` equals 0, with `addr[SEL_LSB-1:1]` all zero, sets `flash_page` to `addr[0]` on the next clock. `wdat0` has no effect.
- R3: A write with region field 2 and `addr[SEL_LSB-1:1]` zero sets `sram_page` to `addr[0]` on the next clock. `wdat0` has no effect.
- R4: A write with region field 1 and `addr[SEL_LSB-1:1]` zero drives `fpga_prog` to 1 (asserted) when `addr[0]` is 0, and to 0 when `addr[0]` is 1, on the next clock.
- R5: A write with region field 4, `addr[SEL_LSB-1:1]` zero and `addr[0]` equal to 1 loads `cfg_dat` with `wdat0` on the next clock. `cfg_clk` is then high for exactly the following clock. This holds when clock writes are separated by at least one idle cycle. Such a write leaves the page bits and `fpga_prog` unchanged.
- R6: A cycle in which `cs` or `wr` is low changes no output.
- R7: A write to any other region field, to any address with a bit of `addr[SEL_LSB-1:1]` set, or to region 4 with `addr[0]` equal to 0, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select for this window, active high |
| wr | input | 1 | Write strobe, active high, sampled with `cs` |
| addr | input | ADDR_W | Address within the window |
| wdat0 | input | 1 | Data bit 0 of the write |
| flash_page | output | 1 | Flash upper address line |
| sram_page | output | 1 | SRAM upper address line |
| fpga_prog | output | 1 | FPGA program output, 1 = asserted |
| cfg_clk | output | 1 | Configuration clock, one pulse per clock write |
| cfg_dat | output | 1 | Configuration data bit |

## Verification
The bench builds the block with `ADDR_W` = 8 and `SEL_LSB` = 5. This keeps the 3-bit region field and leaves four bits between the region field and bit 0, so all 256 addresses can be swept. Each address is tried as a full write and as a cycle with only one of the two strobes high, with the data bit alternating. This reaches every unmapped region code and every stray middle bit, as well as both offsets of each region. The pulse position and width of the configuration clock are checked around every access.

// File: rtl/asc_pkg.sv
package asc_pkg;

  typedef enum logic [1:0] {
    RG_FLASH = 2'd0,
    RG_PROG  = 2'd1,
    RG_SRAM  = 2'd2,
    RG_CCLK  = 2'd3
  } rgn_e;

  localparam int unsigned N_RGN = 4;
  localparam int unsigned N_LVL = 3;

  // Region field value that selects each region index.
  function automatic int unsigned rgn_code(input int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/asc_rgn_dec.sv
module asc_rgn_dec
  import asc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned SEL_LSB = 17
) (
  input  logic              cs,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_RGN-1:0]  hit,
  output logic              off_bit
);
  localparam int unsigned SEL_W = ADDR_W - SEL_LSB;

  logic             mid_zero;
  logic [SEL_W-1:0] sel;

  assign mid_zero = ~|addr[SEL_LSB-1:1];
  assign sel      = addr[ADDR_W-1:SEL_LSB];
  assign off_bit  = addr[0];

  for (genvar i = 0; i < N_RGN; i++) begin : g_hit
    localparam logic [SEL_W-1:0] CODE = SEL_W'(rgn_code(i));
    assign hit[i] = cs & wr & mid_zero & (sel == CODE);
  end
endmodule

// File: rtl/asc_lvl_reg.sv
module asc_lvl_reg #(
  parameter bit INV = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_i,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = bit_i ^ INV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/asc_cclk_gen.sv
module asc_cclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic dat_i,
  output logic cfg_dat,
  output logic cfg_clk
);
  logic pend_q, pend_nxt;
  logic dat_nxt, clk_nxt;

  always_comb begin
    pend_nxt = strobe;
    dat_nxt  = cfg_dat;
    if (strobe) dat_nxt = dat_i;
    clk_nxt  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      cfg_dat <= 1'b0;
      cfg_clk <= 1'b0;
    end else begin
      pend_q  <= pend_nxt;
      cfg_dat <= dat_nxt;
      cfg_clk <= clk_nxt;
    end
  end
endmodule

// File: rtl/addr_strobe_ctl.sv
module addr_strobe_ctl
  import asc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned SEL_LSB = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdat0,
  output logic              flash_page,
  output logic              sram_page,
  output logic              fpga_prog,
  output logic              cfg_clk,
  output logic              cfg_dat
);
  logic [1:0]       rst_sync;
  logic             rst_sn;
  logic [N_RGN-1:0] hit;
  logic             off_bit;
  logic [N_LVL-1:0] lvl;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  asc_rgn_dec #(.ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB)) dec_i (
    .cs(cs), .wr(wr), .addr(addr), .hit(hit), .off_bit(off_bit)
  );

  for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
    asc_lvl_reg #(.INV(i == int'(RG_PROG))) lvl_i (
      .clk(clk), .rst_n(rst_sn), .en(hit[i]), .bit_i(off_bit), .q(lvl[i])
    );
  end

  asc_cclk_gen cclk_i (
    .clk(clk), .rst_n(rst_sn),
    .strobe(hit[RG_CCLK] & off_bit), .dat_i(wdat0),
    .cfg_dat(cfg_dat), .cfg_clk(cfg_clk)
  );

  assign flash_page = lvl[RG_FLASH];
  assign fpga_prog  = lvl[RG_PROG];
  assign sram_page  = lvl[RG_SRAM];
endmodule

// File: rtl/asc_chk.sv
module asc_chk #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned SEL_LSB = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic              flash_page,
  input logic              sram_page,
  input logic              fpga_prog,
  input logic              cfg_clk,
  input logic              cfg_dat
);
  localparam int unsigned SEL_W = ADDR_W - SEL_LSB;

  logic             wr_ok, mid_ok, cclk_wr, mapped;
  logic [SEL_W-1:0] sel;

  assign wr_ok   = cs && wr;
  assign mid_ok  = (addr[SEL_LSB-1:1] == '0);
  assign sel     = addr[ADDR_W-1:SEL_LSB];
  assign cclk_wr = wr_ok && mid_ok && (sel == SEL_W'(4)) && addr[0];
  assign mapped  = mid_ok && ((sel == SEL_W'(0)) || (sel == SEL_W'(1)) ||
                              (sel == SEL_W'(2)) || ((sel == SEL_W'(4)) && addr[0]));

  p_flash_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && mid_ok && sel == SEL_W'(0)) |=> (flash_page == $past(addr[0])));

  p_sram_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && mid_ok && sel == SEL_W'(2)) |=> (sram_page == $past(addr[0])));

  p_prog_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && mid_ok && sel == SEL_W'(1)) |=> (fpga_prog == !$past(addr[0])));

  p_clk_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $past(cclk_wr, 2));

  p_dat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_wr |=> $stable(cfg_dat));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> ($stable(flash_page) && $stable(sram_page) && $stable(fpga_prog)));

  p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !mapped) |=> ($stable(flash_page) && $stable(sram_page) &&
                           $stable(fpga_prog) && $stable(cfg_dat)));
endmodule

bind addr_strobe_ctl asc_chk #(.ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB)) chk_i (
  .clk(clk), .rst_n(rst_sn), .cs(cs), .wr(wr), .addr(addr),
  .flash_page(flash_page), .sram_page(sram_page), .fpga_prog(fpga_prog),
  .cfg_clk(cfg_clk), .cfg_dat(cfg_dat)
);

// File: tb/addr_strobe_ctl_tb_top.sv
module addr_strobe_ctl_tb_top;
  localparam int AW  = 8;
  localparam int LSB = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic cs, wr, wdat0;
  logic [AW-1:0] addr;
  logic flash_page, sram_page, fpga_prog, cfg_clk, cfg_dat;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic m_fp = 0, m_sp = 0, m_pg = 0, m_cd = 0;

  always #10 clk = ~clk;

  addr_strobe_ctl #(.ADDR_W(AW), .SEL_LSB(LSB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .wdat0(wdat0),
    .flash_page(flash_page), .sram_page(sram_page), .fpga_prog(fpga_prog),
    .cfg_clk(cfg_clk), .cfg_dat(cfg_dat)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  task automatic access(input logic c, input logic w, input int a, input logic d);
    string tag;
    int    sel, mid, off;
    logic  pulse;
    sel = a >> LSB;
    mid = (a >> 1) & ((1 << (LSB - 1)) - 1);
    off = a & 1;
    pulse = 1'b0;
    if (!(c && w))       tag = "R6";
    else if (mid != 0)   tag = "R7";
    else begin
      case (sel)
        0: begin tag = "R2"; m_fp = off[0]; end
        1: begin tag = "R4"; m_pg = !off[0]; end
        2: begin tag = "R3"; m_sp = off[0]; end
        4: if (off == 1) begin tag = "R5"; m_cd = d; pulse = 1'b1; end
           else tag = "R7";
        default: tag = "R7";
      endcase
    end
    @(negedge clk);
    cs = c; wr = w; addr = AW'(a); wdat0 = d;
    @(negedge clk);
    cs = 0; wr = 0; addr = '0; wdat0 = ~d;
    check(tag, "flash_page", flash_page, m_fp);
    check(tag, "sram_page",  sram_page,  m_sp);
    check(tag, "fpga_prog",  fpga_prog,  m_pg);
    check(tag, "cfg_dat",    cfg_dat,    m_cd);
    check(tag, "cfg_clk before pulse", cfg_clk, 1'b0);
    @(negedge clk);
    check(tag, "cfg_clk pulse slot", cfg_clk, pulse);
    @(negedge clk);
    check(tag, "cfg_clk after pulse", cfg_clk, 1'b0);
  endtask

  initial begin
    cs = 0; wr = 0; addr = '0; wdat0 = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "flash_page", flash_page, 1'b0);
    check("R1", "sram_page",  sram_page,  1'b0);
    check("R1", "fpga_prog",  fpga_prog,  1'b0);
    check("R1", "cfg_clk",    cfg_clk,    1'b0);
    check("R1", "cfg_dat",    cfg_dat,    1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", "flash_page after release", flash_page, 1'b0);
    check("R1", "fpga_prog after release",  fpga_prog,  1'b0);

    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < (1 << AW); a++) begin
        for (int v = 0; v < 3; v++) begin
          logic d;
          d = 1'(a ^ v ^ pass);
          case (v)
            0: access(1'b1, 1'b1, a, d);
            1: access(1'b0, 1'b1, a, d);
            default: access(1'b1, 1'b0, a, d);
          endcase
        end
      end
    end

    // Directed sequence: R2 and R3 with data opposite to offset, R4 toggle, R5 both data values
    access(1'b1, 1'b1, 32'h01, 1'b0);
    access(1'b1, 1'b1, 32'h41, 1'b0);
    access(1'b1, 1'b1, 32'h20, 1'b1);
    access(1'b1, 1'b1, 32'h81, 1'b1);
    access(1'b1, 1'b1, 32'h81, 1'b0);
    access(1'b1, 1'b1, 32'h80, 1'b1);
    access(1'b1, 1'b1, 32'h00, 1'b1);
    access(1'b1, 1'b1, 32'h21, 1'b0);
    finish_run();
  end
endmodule